// File: doc/BRIEF.md
# DMA Address Translation Walker

This block turns the device virtual address of one DMA access into a physical address. When a request is accepted it computes the address of a single 32-bit page table entry from the page-table base and the window base. It reads that entry through a simple request/response memory port, then either returns the physical address or reports a fault. The page tables have one fixed level, pages are 4 KB, and the block does not cache entries.

A DMA engine offers the address and a read/write flag on a valid/ready handshake. The block accepts one request at a time and stays busy until a one-cycle completion pulse. That pulse carries either the translated address or a fault flag. On a fault the block also records a fault status word and the page-aligned faulting address. Both stay readable on its outputs until the next fault.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `done`, `mem_req_valid`, `fault_status` and `fault_addr` are all 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `mem_req_valid` then rises with `mem_req_addr = (ptb_base << 4) + (((req_addr & ~win_base) >> 10) & ~3)`, computed modulo 2^32 from the inputs sampled at acceptance. `mem_req_addr` holds steady until a cycle with `mem_req_ready` high.
- R3: `mem_rsp_data` carries the entry in byte-lane order: the byte at the lowest address sits in bits 7:0. The entry is the big-endian word formed from those bytes, so data bits 7:0 become entry bits 31:24.
- R4: On success, `done_pa` is `{1'b0, entry[26:8], req_addr[11:0]}`. On a fault, `done_pa` is 0.
- R5: An entry with bit 1 (valid) clear faults for both reads and writes.
- R6: A write to an entry whose bit 2 (write permission) is clear faults. A read of such a valid entry succeeds.
- R7: Entry bit 7 (cache hint) and bit 0 (write-as-zero) have no effect on `done_pa` or `done_fault`.
- R8: On a fault, `fault_status` becomes 32'hC0820000 for a write and 32'hC0860000 for a read. That is: bits 31 and 30 set, 4'h8 in bits 23:20, bit 17 set, and bit 18 set only for a read.
- R9: On a fault, `fault_addr` becomes `req_addr` with bits 11:0 cleared. A successful translation leaves `fault_status` and `fault_addr` unchanged.
- R10: `done` is a one-cycle pulse, issued the cycle after the edge where `mem_rsp_valid` is seen in the waiting state. `req_ready` is low from acceptance until that pulse and is high during it, so one request is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptb_base | input | 32 | Page-table base register value |
| win_base | input | 32 | Lowest address of the translation window |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request can be accepted |
| req_addr | input | 32 | Device virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the entry read |
| mem_req_addr | output | 32 | Byte address of the page table entry |
| mem_rsp_valid | input | 1 | Entry read data present |
| mem_rsp_data | input | 32 | Entry read data, byte-lane order |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Completion was a fault |
| done_pa | output | 32 | Translated physical address |
| fault_status | output | 32 | Last fault status word |
| fault_addr | output | 32 | Last faulting page-aligned address |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle, because `req_ready` returns high exactly while `done` is shown. The bench provokes this by raising `req_valid` for a new translation in the cycle of the pulse. It checks that the pulse still carries the earlier request's result and fault record. It also checks that the next entry read uses the new request's address and window. Random traffic with random memory stalls adds more of these overlaps, mixing faulting and clean completions.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} walk_st_t;

  localparam int PTE_VALID_BIT = 1;
  localparam int PTE_WRITE_BIT = 2;
  localparam int PPN_LSB       = 8;
  localparam int PPN_MSB       = 26;

  localparam logic [31:0] FSR_ERR    = 32'h8000_0000;
  localparam logic [31:0] FSR_LATE   = 32'h4000_0000;
  localparam logic [31:0] FSR_FIXED8 = 32'h0080_0000;
  localparam logic [31:0] FSR_RD     = 32'h0004_0000;
  localparam logic [31:0] FSR_AVAL   = 32'h0002_0000;
endpackage

// File: rtl/xw_ent_addr.sv
module xw_ent_addr #(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] win,
  input  logic [AW-1:0] va,
  output logic [AW-1:0] ent_addr
);
  localparam int IDX_SHIFT = PAGE_SHIFT - 2;

  logic [AW-1:0] offs;

  always_comb begin
    offs     = ((va & ~win) >> IDX_SHIFT) & ~AW'(3);
    ent_addr = (base << 4) + offs;
  end
endmodule

// File: rtl/xw_pte_eval.sv
module xw_pte_eval
  import xw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic [31:0]   raw,
  input  logic [AW-1:0] va,
  input  logic          is_write,
  output logic [AW-1:0] pa,
  output logic          fault,
  output logic [31:0]   fsr
);
  localparam int PPN_W = PPN_MSB - PPN_LSB + 1;

  logic [31:0] pte;

  generate
    if (BIG_ENDIAN) begin : g_swap
      assign pte = {raw[7:0], raw[15:8], raw[23:16], raw[31:24]};
    end else begin : g_flat
      assign pte = raw;
    end
  endgenerate

  logic unused_bits;
  assign unused_bits = ^{pte[31:PPN_MSB+1], pte[PPN_LSB-1:3], pte[0], va[AW-1:PAGE_SHIFT]};

  always_comb begin
    pa    = AW'({pte[PPN_MSB:PPN_LSB], va[PAGE_SHIFT-1:0]});
    fault = !pte[PTE_VALID_BIT] || (is_write && !pte[PTE_WRITE_BIT]);
    fsr   = FSR_ERR | FSR_LATE | FSR_FIXED8 | FSR_AVAL | (is_write ? 32'h0 : FSR_RD);
  end

  initial begin
    if (PPN_W + PAGE_SHIFT > AW) $error("address width too small for page number");
  end
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import xw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ptb_base,
  input  logic [AW-1:0] win_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          done,
  output logic          done_fault,
  output logic [AW-1:0] done_pa,
  output logic [31:0]   fault_status,
  output logic [AW-1:0] fault_addr
);
  walk_st_t      state;
  logic [AW-1:0] va_q;
  logic          wr_q;
  logic [AW-1:0] ent_addr;
  logic [AW-1:0] pa_c;
  logic          fault_c;
  logic [31:0]   fsr_c;

  xw_ent_addr #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
    .base     (ptb_base),
    .win      (win_base),
    .va       (req_addr),
    .ent_addr (ent_addr)
  );

  xw_pte_eval #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .BIG_ENDIAN(BIG_ENDIAN)) u_eval (
    .raw      (mem_rsp_data),
    .va       (va_q),
    .is_write (wr_q),
    .pa       (pa_c),
    .fault    (fault_c),
    .fsr      (fsr_c)
  );

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      va_q         <= '0;
      wr_q         <= 1'b0;
      mem_req_addr <= '0;
      done         <= 1'b0;
      done_fault   <= 1'b0;
      done_pa      <= '0;
      fault_status <= '0;
      fault_addr   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q         <= req_addr;
            wr_q         <= req_write;
            mem_req_addr <= ent_addr;
            state        <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            done       <= 1'b1;
            done_fault <= fault_c;
            done_pa    <= fault_c ? '0 : pa_c;
            if (fault_c) begin
              fault_status <= fsr_c;
              fault_addr   <= {va_q[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
            end
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xw_walk_chk.sv
module xw_walk_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          done,
  input logic          done_fault,
  input logic [AW-1:0] done_pa,
  input logic [31:0]   fault_status,
  input logic [AW-1:0] fault_addr
);
  // R2: entry address held while the read is stalled
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: acceptance makes the walker busy
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && mem_req_valid));

  // R10: never idle while reading the entry
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  // R4: faulting completion carries no address
  assert_fault_pa_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (done && done_fault) |-> (done_pa == '0));

  // R8: fault status layout
  assert_fsr_layout_R8: assert property (@(posedge clk) disable iff (rst)
    (done && done_fault) |-> (fault_status[31:30] == 2'b11 && fault_status[23:20] == 4'h8
                              && fault_status[17] && fault_status[29:24] == '0));

  // R9: fault record changes only with a faulting completion
  assert_fault_rec_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && done_fault) |-> ($stable(fault_status) && $stable(fault_addr)));

  // R9: recorded address is page aligned
  assert_fault_addr_align_R9: assert property (@(posedge clk) disable iff (rst)
    (done && done_fault) |-> (fault_addr[11:0] == '0));
endmodule

bind dma_xlate_walker xw_walk_chk #(.AW(AW)) u_chk (.*);

// File: tb/dma_xlate_walker_test.sv
module dma_xlate_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ptb_base = '0, win_base = '0, req_addr = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        req_ready, mem_req_valid, done, done_fault;
  logic [31:0] mem_req_addr, done_pa, fault_status, fault_addr;

  always #5 clk = ~clk;

  dma_xlate_walker uut (
    .clk(clk), .rst(rst), .ptb_base(ptb_base), .win_base(win_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .done_fault(done_fault), .done_pa(done_pa),
    .fault_status(fault_status), .fault_addr(fault_addr)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_fs = '0, m_fa = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ent_f(input logic [31:0] b, input logic [31:0] w, input logic [31:0] a);
    return (b << 4) + (((a & ~w) >> 10) & 32'hFFFF_FFFC);
  endfunction
  function automatic logic flt_f(input logic [31:0] e, input logic wr);
    return !e[1] || (wr && !e[2]);
  endfunction
  function automatic logic [31:0] pa_f(input logic [31:0] e, input logic [31:0] a);
    return ((e & 32'h07FF_FF00) << 4) | (a & 32'h0000_0FFF);
  endfunction
  function automatic logic [31:0] fsr_f(input logic wr);
    return wr ? 32'hC082_0000 : 32'hC086_0000;
  endfunction
  function automatic logic [31:0] lanes_f(input logic [31:0] e);
    return {e[7:0], e[15:8], e[23:16], e[31:24]};
  endfunction

  // One translation; the request may already be presented (chained).
  task automatic xact(input logic [31:0] a, input logic wr, input logic [31:0] e,
                      input logic [31:0] b, input logic [31:0] w, input bit chain,
                      input logic [31:0] na, input logic nwr, input logic [31:0] nb, input logic [31:0] nw);
    logic [31:0] ea;
    logic        f;
    int          k;
    ea = ent_f(b, w, a);
    f  = flt_f(e, wr);
    if (!req_valid) begin
      req_addr = a; req_write = wr; ptb_base = b; win_base = w; req_valid = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "busy after accept", {31'd0, req_ready}, 32'd0);
    chk("R2", "entry read issued", {31'd0, mem_req_valid}, 32'd1);
    chk("R2", "entry address", mem_req_addr, ea);
    chk("R9", "fault status kept while busy", fault_status, m_fs);
    ptb_base = $urandom; win_base = $urandom; req_addr = $urandom;
    k = $urandom % 4;
    repeat (k) begin
      @(negedge clk);
      chk("R2", "entry address held in stall", mem_req_addr, ea);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    k = $urandom % 4;
    repeat (k) begin
      chk("R10", "no early done", {31'd0, done}, 32'd0);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = lanes_f(e);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = $urandom;
    if (f) begin
      m_fs = fsr_f(wr);
      m_fa = a & 32'hFFFF_F000;
    end
    chk("R10", "done pulse", {31'd0, done}, 32'd1);
    chk("R10", "ready during done", {31'd0, req_ready}, 32'd1);
    chk("R5 R6", "fault flag", {31'd0, done_fault}, {31'd0, f});
    chk("R4 R3", "physical address", done_pa, f ? 32'd0 : pa_f(e, a));
    chk("R8", "fault status", fault_status, m_fs);
    chk("R9", "fault address", fault_addr, m_fa);
    if (chain) begin
      req_addr = na; req_write = nwr; ptb_base = nb; win_base = nw; req_valid = 1'b1;
    end else begin
      @(negedge clk);
      chk("R10", "done is one cycle", {31'd0, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R1", "fault_status", fault_status, 32'd0);
    chk("R1", "fault_addr", fault_addr, 32'd0);

    // R3 asymmetric bytes, R4 success, 2 GB window
    xact(32'h8123_4567, 1'b0, 32'h0012_3406, 32'h0010_0000, 32'h8000_0000, 0, 0, 0, 0, 0);
    // R7 cache hint and write-as-zero bits set, same result
    xact(32'h8123_4567, 1'b1, 32'h0012_3487, 32'h0010_0000, 32'h8000_0000, 0, 0, 0, 0, 0);
    // R5 invalid read and invalid write
    xact(32'hFF00_2ABC, 1'b0, 32'h0555_5504, 32'h0000_4000, 32'hFF00_0000, 0, 0, 0, 0, 0);
    xact(32'hFF01_3DEF, 1'b1, 32'h0555_5584, 32'h0000_4000, 32'hFF00_0000, 0, 0, 0, 0, 0);
    // R6 read-only page: read passes, write faults
    xact(32'hC000_5123, 1'b0, 32'h07FF_FF02, 32'h07FF_FC00, 32'hC000_0000, 0, 0, 0, 0, 0);
    xact(32'hC777_7123, 1'b1, 32'h0000_0103, 32'h07FF_FC00, 32'hC000_0000, 0, 0, 0, 0, 0);
    // R9 success after fault keeps record; R10 chained request in done cycle
    xact(32'hFE12_3456, 1'b1, 32'h0000_0006, 32'h0000_0400, 32'hFE00_0000, 1,
         32'hF876_5432, 1'b0, 32'h0123_4400, 32'hF800_0000);
    xact(32'hF876_5432, 1'b0, 32'h0000_0000, 32'h0123_4400, 32'hF800_0000, 1,
         32'hE000_0FFF, 1'b1, 32'h0000_0000, 32'hE000_0000);
    xact(32'hE000_0FFF, 1'b1, 32'h0765_4386, 32'h0000_0000, 32'hE000_0000, 0, 0, 0, 0, 0);

    // random traffic, some chained
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, e, b, w;
      logic        wr;
      a  = $urandom;
      wr = $urandom % 2;
      e  = $urandom;
      if (($urandom % 4) != 0) e[1] = 1'b1;
      b  = $urandom & 32'h07FF_FC00;
      w  = 32'hFFFF_FFFF << (24 + ($urandom % 8));
      if (req_valid) begin
        a = req_addr; wr = req_write; b = ptb_base; w = win_base;
      end
      if (i < 299 && ($urandom % 3) == 0)
        xact(a, wr, e, b, w, 1, $urandom, 1'($urandom % 2),
             $urandom & 32'h07FF_FC00, 32'hFFFF_FFFF << (24 + ($urandom % 8)));
      else
        xact(a, wr, e, b, w, 0, 0, 0, 0, 0);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule